// File: doc/BRIEF.md
# Dual-Direction Registered Bus Transceiver

This block joins two byte-wide ports, an A side and a B side, through a pair of storage registers per byte lane. One register loads from the A side and feeds the B side. The other loads from the B side and feeds the A side. Each direction of each lane has its own capture clock, its own active-low capture enable and its own active-low drive enable. Two lanes of eight bits make up the default sixteen-bit width.

Each shared pin is split into a receive value, an external-drive flag supplied by the surrounding model, a transmit value and a transmit enable. The level a pin carries is the external value when something outside drives it, the block's own transmit value when the block drives it, and otherwise nothing. With the hold option on, an undriven pin reads as the last level it carried when its capturing clock last rose. With the option off, an undriven pin reads as unknown. A synchronous active-low reset clears the storage registers and the hold state in whichever clock domain sees a rising edge while reset is low.

Top module: `brt_xcvr`

## Requirements
- R1: On a rising edge of a lane's A-to-B clock with that lane's A-to-B capture enable low, the lane's A-to-B register loads the level on its A pins. The loaded value appears on the lane's B transmit value after that edge.
- R2: A rising A-to-B clock edge with the capture enable high leaves the register unchanged. With no clock edge, the register is unchanged whatever the enable and data do.
- R3: For each lane, the B transmit enable bits are all 1 while the A-to-B drive enable is low and all 0 while it is high, independent of clocks and data. The B transmit value always equals the stored A-to-B value.
- R4: The B-to-A direction follows R1 to R3 with its own clock, capture enable and drive enable. It loads from the B pins and transmits on the A pins.
- R5: Lane 0 owns bits 7:0 and lane 1 owns bits 15:8. The six controls of one lane have no effect on the other lane's registers or outputs.
- R6: With hold on (default), a pin that is driven by neither side reads as the level it last carried at a rising edge of the clock that captures from it. That level may come from an external drive or from the block's own drive.
- R7: A rising edge of a direction's clock with rst_n low clears that lane's register in that direction to zero. The same edge clears the hold state of the pins that direction captures from.
- R8: While a lane drives its B pins and nothing external does, a B-to-A capture loads the stored A-to-B value. This path passes through a register and has no combinational loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Synchronous active-low reset, sampled by every clock |
| clk_ab | input | 2 | A-to-B capture clock, one per lane |
| cap_ab_n | input | 2 | A-to-B capture enable, active low, one per lane |
| drv_ab_n | input | 2 | B-side drive enable, active low, one per lane |
| clk_ba | input | 2 | B-to-A capture clock, one per lane |
| cap_ba_n | input | 2 | B-to-A capture enable, active low, one per lane |
| drv_ba_n | input | 2 | A-side drive enable, active low, one per lane |
| a_rx | input | 16 | Level driven onto the A pins from outside |
| a_rx_on | input | 16 | Per-bit flag: outside is driving that A pin |
| a_tx | output | 16 | Value the block drives onto the A pins |
| a_tx_on | output | 16 | Per-bit enable of the A-side drive |
| b_rx | input | 16 | Level driven onto the B pins from outside |
| b_rx_on | input | 16 | Per-bit flag: outside is driving that B pin |
| b_tx | output | 16 | Value the block drives onto the B pins |
| b_tx_on | output | 16 | Per-bit enable of the B-side drive |

## Verification
The checks assume that no pin is driven from outside and by the block at the same time. The bench raises an external drive flag only on lanes whose drive enable on that side is high. It also resolves every pin each cycle and counts any overlap as a miscompare. The capture and hold checks assume that clocks are gated only while they are low. The bench therefore changes its per-lane clock gates and all other inputs at the falling edge of its base clock.

// File: rtl/brt_pkg.sv
// Shared definitions for the registered bus transceiver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package brt_pkg;
    localparam int BRT_LANE_W_DEF = 8;
    localparam int BRT_LANES_DEF  = 2;

    // Drive state of one pin group as seen by the hold logic.
    typedef enum logic [1:0] {
        PIN_FLOAT = 2'b00,
        PIN_OWN   = 2'b01,
        PIN_EXT   = 2'b10
    } pin_src_e;
endpackage

// File: rtl/brt_pin_sense.sv
// Resolves what one lane's pin group carries and what an input register sees.
// Assumes an external drive and the block's own drive never overlap on a bit.
// The hold state is clocked by the clock of the register that captures from it.
module brt_pin_sense #(
    parameter int W        = 8,
    parameter bit BUS_HOLD = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] ext_on,
    input  logic [W-1:0] own_val,
    input  logic         own_on,
    output logic [W-1:0] sense
);
    import brt_pkg::*;

    logic [W-1:0] driven;
    logic [W-1:0] level;
    pin_src_e     src [W];

    // Classify each bit by who is driving it and pick the carried level.
    always_comb begin
        for (int k = 0; k < W; k++) begin
            if (ext_on[k])   src[k] = PIN_EXT;
            else if (own_on) src[k] = PIN_OWN;
            else             src[k] = PIN_FLOAT;
            driven[k] = (src[k] != PIN_FLOAT);
            level[k]  = (src[k] == PIN_EXT) ? ext_val[k] : own_val[k];
        end
    end

    generate
        if (BUS_HOLD) begin : g_hold
            logic [W-1:0] held;

            // Remember the level last seen on each driven bit.
            always_ff @(posedge clk) begin
                if (!rst_n) held <= '0;
                else        held <= (driven & level) | (~driven & held);
            end

            // Undriven bits read back their remembered level.
            always_comb sense = (driven & level) | (~driven & held);

            // R6
            hold_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (((sense ^ $past(level)) & $past(driven) & ~driven) == '0));
        end else begin : g_nohold
            // Undriven bits read as unknown.
            always_comb begin
                for (int k = 0; k < W; k++) sense[k] = driven[k] ? level[k] : 1'bx;
            end
        end
    endgenerate

    // R6 (input assumption: no overlap of drives)
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_on & {W{own_on}}) == '0);
endmodule

// File: rtl/brt_dir_reg.sv
// One direction of one lane: a capture register with an active-low capture enable
// and an active-low drive enable for the far side.
// Assumes the clock is gated only while low.
module brt_dir_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_n,
    input  logic         drv_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] tx,
    output logic [W-1:0] tx_on,
    output logic         own_on
);
    logic [W-1:0] q;

    // Load the near-side level when capture is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!cap_n) q <= d;
    end

    // Present the stored value and its drive enable to the far side.
    always_comb begin
        tx     = q;
        own_on = ~drv_n;
        tx_on  = {W{own_on}};
    end

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_n |=> tx == $past(d));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_n |=> $stable(tx));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> tx == '0);
endmodule

// File: rtl/brt_lane.sv
// One byte lane: both direction registers and the hold logic of both pin groups.
// A pins feed the A-to-B register, B pins feed the B-to-A register; the block's
// own drive on a side is fed back only through a register, never combinationally.
module brt_lane #(
    parameter int W        = 8,
    parameter bit BUS_HOLD = 1'b1
) (
    input  logic         rst_n,
    input  logic         clk_ab,
    input  logic         cap_ab_n,
    input  logic         drv_ab_n,
    input  logic         clk_ba,
    input  logic         cap_ba_n,
    input  logic         drv_ba_n,
    input  logic [W-1:0] a_rx,
    input  logic [W-1:0] a_rx_on,
    output logic [W-1:0] a_tx,
    output logic [W-1:0] a_tx_on,
    input  logic [W-1:0] b_rx,
    input  logic [W-1:0] b_rx_on,
    output logic [W-1:0] b_tx,
    output logic [W-1:0] b_tx_on
);
    logic [W-1:0] a_sense, b_sense;
    logic         a_own_on, b_own_on;

    brt_pin_sense #(.W(W), .BUS_HOLD(BUS_HOLD)) u_sense_a (
        .clk(clk_ab), .rst_n(rst_n), .ext_val(a_rx), .ext_on(a_rx_on),
        .own_val(a_tx), .own_on(a_own_on), .sense(a_sense));

    brt_pin_sense #(.W(W), .BUS_HOLD(BUS_HOLD)) u_sense_b (
        .clk(clk_ba), .rst_n(rst_n), .ext_val(b_rx), .ext_on(b_rx_on),
        .own_val(b_tx), .own_on(b_own_on), .sense(b_sense));

    brt_dir_reg #(.W(W)) u_ab (
        .clk(clk_ab), .rst_n(rst_n), .cap_n(cap_ab_n), .drv_n(drv_ab_n),
        .d(a_sense), .tx(b_tx), .tx_on(b_tx_on), .own_on(b_own_on));

    brt_dir_reg #(.W(W)) u_ba (
        .clk(clk_ba), .rst_n(rst_n), .cap_n(cap_ba_n), .drv_n(drv_ba_n),
        .d(b_sense), .tx(a_tx), .tx_on(a_tx_on), .own_on(a_own_on));

    // R8
    loopback_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (!cap_ba_n && !drv_ab_n && b_rx_on == '0) |=> a_tx == $past(b_tx));
endmodule

// File: rtl/brt_xcvr.sv
// Top of the registered bus transceiver: LANES independent byte lanes, each with
// its own six controls. Pins are split into receive value, external-drive flag,
// transmit value and transmit enable.
module brt_xcvr #(
    parameter int LANES    = brt_pkg::BRT_LANES_DEF,
    parameter int LANE_W   = brt_pkg::BRT_LANE_W_DEF,
    parameter bit BUS_HOLD = 1'b1,
    localparam int BUS_W   = LANES * LANE_W
) (
    input  logic             rst_n,
    input  logic [LANES-1:0] clk_ab,
    input  logic [LANES-1:0] cap_ab_n,
    input  logic [LANES-1:0] drv_ab_n,
    input  logic [LANES-1:0] clk_ba,
    input  logic [LANES-1:0] cap_ba_n,
    input  logic [LANES-1:0] drv_ba_n,
    input  logic [BUS_W-1:0] a_rx,
    input  logic [BUS_W-1:0] a_rx_on,
    output logic [BUS_W-1:0] a_tx,
    output logic [BUS_W-1:0] a_tx_on,
    input  logic [BUS_W-1:0] b_rx,
    input  logic [BUS_W-1:0] b_rx_on,
    output logic [BUS_W-1:0] b_tx,
    output logic [BUS_W-1:0] b_tx_on
);
    // One lane per byte slice; lane i owns bits i*LANE_W and up.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        brt_lane #(.W(LANE_W), .BUS_HOLD(BUS_HOLD)) u_lane (
            .rst_n   (rst_n),
            .clk_ab  (clk_ab[i]),
            .cap_ab_n(cap_ab_n[i]),
            .drv_ab_n(drv_ab_n[i]),
            .clk_ba  (clk_ba[i]),
            .cap_ba_n(cap_ba_n[i]),
            .drv_ba_n(drv_ba_n[i]),
            .a_rx    (a_rx   [i*LANE_W +: LANE_W]),
            .a_rx_on (a_rx_on[i*LANE_W +: LANE_W]),
            .a_tx    (a_tx   [i*LANE_W +: LANE_W]),
            .a_tx_on (a_tx_on[i*LANE_W +: LANE_W]),
            .b_rx    (b_rx   [i*LANE_W +: LANE_W]),
            .b_rx_on (b_rx_on[i*LANE_W +: LANE_W]),
            .b_tx    (b_tx   [i*LANE_W +: LANE_W]),
            .b_tx_on (b_tx_on[i*LANE_W +: LANE_W]));
    end
endmodule

// File: tb/brt_xcvr_test.sv
module brt_xcvr_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  run_ab, run_ba, cap_ab_n, drv_ab_n, cap_ba_n, drv_ba_n;
    logic [15:0] a_rx, a_rx_on, b_rx, b_rx_on;
    logic [15:0] a_tx, a_tx_on, b_tx, b_tx_on;
    logic [1:0]  clk_ab, clk_ba;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    string cur_req = "R7";

    // behavioural reference state
    logic [7:0]  m_ab [2];
    logic [7:0]  m_ba [2];
    logic [15:0] m_ha, m_hb;
    bit          m_valid = 0;

    always #10 clk = ~clk;                 // 50 MHz
    assign clk_ab = {2{clk}} & run_ab;     // gates change only while clk is low
    assign clk_ba = {2{clk}} & run_ba;

    brt_xcvr uut (
        .rst_n(rst_n), .clk_ab(clk_ab), .cap_ab_n(cap_ab_n), .drv_ab_n(drv_ab_n),
        .clk_ba(clk_ba), .cap_ba_n(cap_ba_n), .drv_ba_n(drv_ba_n),
        .a_rx(a_rx), .a_rx_on(a_rx_on), .a_tx(a_tx), .a_tx_on(a_tx_on),
        .b_rx(b_rx), .b_rx_on(b_rx_on), .b_tx(b_tx), .b_tx_on(b_tx_on));

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare outputs with the model, apply new inputs, advance the model by one edge.
    task automatic step(input logic r, input logic [1:0] rab, cab, dab, rba, cba, dba,
                        input logic [15:0] av, aon, bv, bon);
        logic [15:0] ea;
        logic [15:0] eb;
        logic [15:0] sa, sb;
        if (m_valid) begin
            chk(cur_req, "b_tx", b_tx, {m_ab[1], m_ab[0]});
            chk(cur_req, "a_tx", a_tx, {m_ba[1], m_ba[0]});
            chk("R3", "b_tx_on", b_tx_on, {{8{~drv_ab_n[1]}}, {8{~drv_ab_n[0]}}});
            chk("R4", "a_tx_on", a_tx_on, {{8{~drv_ba_n[1]}}, {8{~drv_ba_n[0]}}});
        end
        // never drive from outside where the block drives
        ea = aon & {{8{dba[1]}}, {8{dba[0]}}};
        eb = bon & {{8{dab[1]}}, {8{dab[0]}}};
        rst_n = r; run_ab = rab; cap_ab_n = cab; drv_ab_n = dab;
        run_ba = rba; cap_ba_n = cba; drv_ba_n = dba;
        a_rx = av; a_rx_on = ea; b_rx = bv; b_rx_on = eb;
        #1;
        chk("R6", "a pin contention", a_rx_on & a_tx_on, 16'h0);
        chk("R6", "b pin contention", b_rx_on & b_tx_on, 16'h0);
        // level seen on each pin at the coming edge
        for (int l = 0; l < 2; l++) begin
            for (int k = 0; k < 8; k++) begin
                int i = l * 8 + k;
                sa[i] = ea[i] ? av[i] : (!dba[l] ? m_ba[l][k] : m_ha[i]);
                sb[i] = eb[i] ? bv[i] : (!dab[l] ? m_ab[l][k] : m_hb[i]);
            end
        end
        for (int l = 0; l < 2; l++) begin
            if (rab[l]) begin
                if (!r) begin m_ab[l] = 8'h0; m_ha[l*8 +: 8] = 8'h0; end
                else begin
                    if (!cab[l]) m_ab[l] = sa[l*8 +: 8];
                    m_ha[l*8 +: 8] = sa[l*8 +: 8];
                end
            end
            if (rba[l]) begin
                if (!r) begin m_ba[l] = 8'h0; m_hb[l*8 +: 8] = 8'h0; end
                else begin
                    if (!cba[l]) m_ba[l] = sb[l*8 +: 8];
                    m_hb[l*8 +: 8] = sb[l*8 +: 8];
                end
            end
        end
        if (!r && rab == 2'b11 && rba == 2'b11) m_valid = 1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 0; run_ab = 0; run_ba = 0; cap_ab_n = 2'b11; drv_ab_n = 2'b11;
        cap_ba_n = 2'b11; drv_ba_n = 2'b11; a_rx = 0; a_rx_on = 0; b_rx = 0; b_rx_on = 0;
        @(negedge clk);
        // R7: reset clears both directions
        cur_req = "R7";
        for (int n = 0; n < 3; n++)
            step(0, 2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        chk("R7", "b_tx after reset", b_tx, 16'h0);
        chk("R7", "a_tx after reset", a_tx, 16'h0);
        // R1: capture A into the A-to-B register and drive B
        cur_req = "R1";
        step(1, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h1234, 16'hFFFF, 16'h0, 16'h0);
        chk("R1", "b_tx after capture", b_tx, 16'h1234);
        chk("R3", "b_tx_on with drive enabled", b_tx_on, 16'hFFFF);
        // R2: capture disabled, then no clock edge
        cur_req = "R2";
        step(1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 16'hFFFF, 16'hFFFF, 16'h0, 16'h0);
        step(1, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'hEEEE, 16'hFFFF, 16'h0, 16'h0);
        chk("R2", "b_tx held", b_tx, 16'h1234);
        // R3: drive enable high floats B
        cur_req = "R3";
        step(1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
        step(1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R3", "b_tx_on released", b_tx_on, 16'h0);
        // R4: B-to-A capture and drive
        cur_req = "R4";
        step(1, 2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 16'h0, 16'h0, 16'hBEEF, 16'hFFFF);
        chk("R4", "a_tx after capture", a_tx, 16'hBEEF);
        chk("R4", "a_tx_on enabled", a_tx_on, 16'hFFFF);
        // R5: lane 1 controls only
        cur_req = "R5";
        step(1, 2'b11, 2'b01, 2'b11, 2'b00, 2'b11, 2'b11, 16'hC3C3, 16'hFFFF, 16'h0, 16'h0);
        chk("R5", "only upper lane loads", b_tx, 16'hC334);
        // R6: hold on A pins after external drive is released
        cur_req = "R6";
        step(1, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h5A5A, 16'hFFFF, 16'h0, 16'h0);
        step(1, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11, 16'h0000, 16'h0000, 16'h0, 16'h0);
        step(1, 2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R6", "held level captured", b_tx, 16'h5A5A);
        // R8: block drives B, B-to-A loads it back
        cur_req = "R8";
        step(1, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
        chk("R8", "loopback into a_tx", a_tx, 16'h5A5A);
        // mixed random traffic, with occasional reset
        cur_req = "R1";
        for (int n = 0; n < 600; n++) begin
            logic r;
            r = ($urandom_range(0, 40) != 0);
            step(r, 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
        end
        step(1, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11, 16'h0, 16'h0, 16'h0, 16'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule